// File: doc/BRIEF.md
# Parallel Rank-Count List Pruner

This block chooses which of the 2L candidate paths in a list decoder survive a decision step, without sorting them. Every candidate is compared against every other in the same cycle. Each candidate's rank is the number of candidates whose metric is less than or equal to its own, counting itself. A candidate whose rank is larger than the list size L is dropped. Smaller metrics are therefore the ones kept.

The caller presents 2L unsigned path metrics with a valid strobe. One clock later the block returns four results:

- a keep mask,
- the rank of every candidate,
- the number of survivors,
- an underfill flag.

Tied metrics raise one another's ranks. A tie that straddles the cut drops all of the tied candidates, so fewer than L may survive. The underfill flag tells the list manager that some list slots will be empty after this step.

Top module: `rank_prune`

## Requirements
- R1: The rank of candidate i equals the number of candidates j (i itself included) with metric_j <= metric_i. Candidate i occupies bits [i*METRIC_W +: METRIC_W] of `in_metrics` and bits [i*CNT_W +: CNT_W] of `rank_flat`, where CNT_W = clog2(2L+1).
- R2: Bit i of `keep_mask` is 1 exactly when the rank of candidate i is at most L. Tied candidates whose rank exceeds L are all dropped.
- R3: When all 2L metrics are distinct, exactly L bits of `keep_mask` are set, and they mark the L smallest metrics.
- R4: `kept_count` equals the number of ones in `keep_mask`.
- R5: `underfill` is 1 exactly when `kept_count` is below L.
- R6: `out_valid` is high in the cycle after a cycle with `in_valid` high, and the results for those metrics are on the outputs in that same cycle.
- R7: After a cycle without `in_valid`, `out_valid` is low and `keep_mask`, `rank_flat`, `kept_count` and `underfill` keep their previous values.
- R8: Synchronous reset clears `out_valid`, `keep_mask`, `rank_flat`, `kept_count` and `underfill` to zero. Reset takes priority over an `in_valid` asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Metrics on `in_metrics` are to be ranked |
| in_metrics | input | 2L*METRIC_W | Unsigned candidate metrics, candidate 0 in the low bits |
| out_valid | output | 1 | Results below belong to the previous valid input |
| keep_mask | output | 2L | 1 marks a surviving candidate |
| rank_flat | output | 2L*CNT_W | Rank of every candidate |
| kept_count | output | CNT_W | Number of survivors |
| underfill | output | 1 | Fewer than L survivors |

## Verification
Two events can land on the same clock edge. A new metric set can be captured while the previous result is still being presented, and a reset can arrive together with an `in_valid`. The first case is provoked by back-to-back valid cycles carrying different metrics, and the second by raising reset and `in_valid` together. In the back-to-back case, each result is compared in its own cycle against a reference that sorts the metrics. In the reset case, every output must read zero one cycle later, with no trace of the captured metrics.

// File: rtl/prc_pkg.sv
package prc_pkg;

    // Bits needed to hold a count from 0 up to n inclusive.
    function automatic int count_width(input int n);
        return $clog2(n + 1);
    endfunction

    // Pipeline state of the single output register stage.
    typedef enum logic {
        STAGE_EMPTY = 1'b0,
        STAGE_FRESH = 1'b1
    } stage_e;

endpackage

// File: rtl/prc_cmp_matrix.sv
module prc_cmp_matrix #(
    parameter int NCAND    = 8,
    parameter int METRIC_W = 16
) (
    input  logic [NCAND*METRIC_W-1:0] metrics,
    output logic [NCAND*NCAND-1:0]    ge_bits
);
    // ge_bits[i*NCAND+j] is 1 when metric j does not exceed metric i.
    for (genvar gi = 0; gi < NCAND; gi++) begin : g_row
        for (genvar gj = 0; gj < NCAND; gj++) begin : g_col
            if (gi == gj) begin : g_self
                assign ge_bits[gi*NCAND+gj] = 1'b1;
            end else begin : g_pair
                assign ge_bits[gi*NCAND+gj] =
                    metrics[gi*METRIC_W +: METRIC_W] >= metrics[gj*METRIC_W +: METRIC_W];
            end
        end
    end
endmodule

// File: rtl/prc_rank_sum.sv
module prc_rank_sum #(
    parameter int NCAND = 8,
    parameter int CNT_W = 4
) (
    input  logic [NCAND*NCAND-1:0] ge_bits,
    output logic [NCAND*CNT_W-1:0] ranks
);
    // One adder chain per candidate row.
    for (genvar gi = 0; gi < NCAND; gi++) begin : g_row
        logic [CNT_W-1:0] acc;
        always_comb begin
            acc = '0;
            for (int j = 0; j < NCAND; j++) begin
                acc = acc + CNT_W'(ge_bits[gi*NCAND+j]);
            end
        end
        assign ranks[gi*CNT_W +: CNT_W] = acc;
    end
endmodule

// File: rtl/prc_out_stage.sv
module prc_out_stage
    import prc_pkg::*;
#(
    parameter int NCAND     = 8,
    parameter int CNT_W     = 4,
    parameter int LIST_SIZE = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [NCAND*CNT_W-1:0] rank_in,
    output logic                   out_valid,
    output logic [NCAND-1:0]       keep_mask,
    output logic [NCAND*CNT_W-1:0] rank_out,
    output logic [CNT_W-1:0]       kept_count,
    output logic                   underfill
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(LIST_SIZE);

    logic [NCAND-1:0] keep_next;
    logic [CNT_W-1:0] count_next;
    stage_e           stage_q;

    for (genvar gi = 0; gi < NCAND; gi++) begin : g_thresh
        assign keep_next[gi] = rank_in[gi*CNT_W +: CNT_W] <= LIMIT;
    end

    always_comb begin
        count_next = '0;
        for (int i = 0; i < NCAND; i++) begin
            count_next = count_next + CNT_W'(keep_next[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q    <= STAGE_EMPTY;
            keep_mask  <= '0;
            rank_out   <= '0;
            kept_count <= '0;
            underfill  <= 1'b0;
        end else begin
            stage_q <= in_valid ? STAGE_FRESH : STAGE_EMPTY;
            if (in_valid) begin
                keep_mask  <= keep_next;
                rank_out   <= rank_in;
                kept_count <= count_next;
                underfill  <= count_next < LIMIT;
            end
        end
    end

    assign out_valid = (stage_q == STAGE_FRESH);
endmodule

// File: rtl/rank_prune.sv
module rank_prune
    import prc_pkg::*;
#(
    parameter int LIST_SIZE = 4,
    parameter int METRIC_W  = 16,
    localparam int NCAND    = 2 * LIST_SIZE,
    localparam int CNT_W    = count_width(NCAND)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [NCAND*METRIC_W-1:0] in_metrics,
    output logic                      out_valid,
    output logic [NCAND-1:0]          keep_mask,
    output logic [NCAND*CNT_W-1:0]    rank_flat,
    output logic [CNT_W-1:0]          kept_count,
    output logic                      underfill
);
    logic [NCAND*NCAND-1:0] ge_bits;
    logic [NCAND*CNT_W-1:0] ranks;

    prc_cmp_matrix #(.NCAND(NCAND), .METRIC_W(METRIC_W)) u_cmp (
        .metrics (in_metrics),
        .ge_bits (ge_bits)
    );

    prc_rank_sum #(.NCAND(NCAND), .CNT_W(CNT_W)) u_sum (
        .ge_bits (ge_bits),
        .ranks   (ranks)
    );

    prc_out_stage #(.NCAND(NCAND), .CNT_W(CNT_W), .LIST_SIZE(LIST_SIZE)) u_out (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .rank_in    (ranks),
        .out_valid  (out_valid),
        .keep_mask  (keep_mask),
        .rank_out   (rank_flat),
        .kept_count (kept_count),
        .underfill  (underfill)
    );
endmodule

// File: rtl/rank_prune_chk.sv
module rank_prune_chk #(
    parameter int LIST_SIZE = 4,
    parameter int NCAND     = 8,
    parameter int CNT_W     = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic                   out_valid,
    input logic [NCAND-1:0]       keep_mask,
    input logic [NCAND*CNT_W-1:0] rank_flat,
    input logic [CNT_W-1:0]       kept_count,
    input logic                   underfill
);
    logic all_ranks_pos;
    logic top_rank_seen;
    logic keep_agrees;

    always_comb begin
        all_ranks_pos = 1'b1;
        top_rank_seen = 1'b0;
        keep_agrees   = 1'b1;
        for (int i = 0; i < NCAND; i++) begin
            if (rank_flat[i*CNT_W +: CNT_W] == '0) all_ranks_pos = 1'b0;
            if (rank_flat[i*CNT_W +: CNT_W] == CNT_W'(NCAND)) top_rank_seen = 1'b1;
            if (keep_mask[i] != (rank_flat[i*CNT_W +: CNT_W] <= CNT_W'(LIST_SIZE)))
                keep_agrees = 1'b0;
        end
    end

    // R1: every rank counts at least itself, and the largest metric ranks 2L
    assert_rank_bounds_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (all_ranks_pos && top_rank_seen));

    assert_keep_threshold_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> keep_agrees);

    assert_kept_count_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones(keep_mask) == int'(kept_count)));

    assert_underfill_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (underfill == (kept_count < CNT_W'(LIST_SIZE))));

    assert_valid_latency_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(keep_mask) && $stable(rank_flat)
                       && $stable(kept_count) && $stable(underfill)));

    assert_reset_clear_R8: assert property (@(posedge clk)
        rst |=> (!out_valid && keep_mask == '0 && rank_flat == '0
                 && kept_count == '0 && !underfill));
endmodule

bind rank_prune rank_prune_chk #(
    .LIST_SIZE (LIST_SIZE),
    .NCAND     (NCAND),
    .CNT_W     (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .out_valid  (out_valid),
    .keep_mask  (keep_mask),
    .rank_flat  (rank_flat),
    .kept_count (kept_count),
    .underfill  (underfill)
);

// File: tb/rank_prune_test.sv
module rank_prune_test;
    localparam int L   = 4;
    localparam int MW  = 16;
    localparam int NC  = 2 * L;
    localparam int CW  = $clog2(NC + 1);
    localparam int NV  = 8;

    // Candidate 7 is written first (most significant), candidate 0 last.
    localparam logic [NC*MW-1:0] VECS [NV] = '{
        {16'd80, 16'd70, 16'd60, 16'd50, 16'd40, 16'd30, 16'd20, 16'd10},
        {16'd1,  16'd2,  16'd3,  16'd4,  16'd5,  16'd6,  16'd7,  16'd8},
        {16'd5,  16'd5,  16'd5,  16'd5,  16'd5,  16'd5,  16'd5,  16'd5},
        {16'd9,  16'd8,  16'd7,  16'd7,  16'd7,  16'd2,  16'd2,  16'd1},
        {16'hFFFF, 16'd0, 16'hFFFF, 16'd0, 16'hFFFE, 16'd1, 16'hFFFF, 16'd2},
        {16'd9,  16'd4,  16'd9,  16'd4,  16'd9,  16'd4,  16'd9,  16'd4},
        {16'd300, 16'd17, 16'd4095, 16'd256, 16'd17, 16'd999, 16'd12, 16'd40000},
        {16'd6,  16'd6,  16'd6,  16'd6,  16'd6,  16'd6,  16'd6,  16'd1}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [NC*MW-1:0]  in_metrics = '0;
    logic              out_valid;
    logic [NC-1:0]     keep_mask;
    logic [NC*CW-1:0]  rank_flat;
    logic [CW-1:0]     kept_count;
    logic              underfill;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    rank_prune #(.LIST_SIZE(L), .METRIC_W(MW)) uut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_metrics (in_metrics),
        .out_valid  (out_valid),
        .keep_mask  (keep_mask),
        .rank_flat  (rank_flat),
        .kept_count (kept_count),
        .underfill  (underfill)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // Reference: sort the metrics; candidate i survives iff its metric is
    // strictly below the (L+1)-th smallest value.
    task automatic check_result(input logic [NC*MW-1:0] m, input string tag);
        logic [MW-1:0]    s [NC];
        logic [MW-1:0]    t;
        logic [NC-1:0]    exp_mask;
        logic [NC*CW-1:0] exp_rank;
        int               exp_kept;
        bit               distinct;
        for (int i = 0; i < NC; i++) s[i] = m[i*MW +: MW];
        for (int a = 0; a < NC - 1; a++)
            for (int b = 0; b < NC - 1 - a; b++)
                if (s[b] > s[b+1]) begin t = s[b]; s[b] = s[b+1]; s[b+1] = t; end
        distinct = 1'b1;
        for (int k = 0; k < NC - 1; k++) if (s[k] == s[k+1]) distinct = 1'b0;
        exp_kept = 0;
        for (int i = 0; i < NC; i++) begin
            int r;
            r = 0;
            for (int k = 0; k < NC; k++) if (s[k] <= m[i*MW +: MW]) r++;
            exp_rank[i*CW +: CW] = CW'(r);
            exp_mask[i] = m[i*MW +: MW] < s[L];
            if (exp_mask[i]) exp_kept++;
        end
        check(out_valid == 1'b1, "R6", {tag, " out_valid"}, 64'(out_valid), 64'd1);
        check(rank_flat == exp_rank, "R1", {tag, " ranks"}, 64'(rank_flat), 64'(exp_rank));
        check(keep_mask == exp_mask, "R2", {tag, " keep_mask"}, 64'(keep_mask), 64'(exp_mask));
        if (distinct)
            check(exp_kept == L && keep_mask == exp_mask, "R3", {tag, " distinct survivors"},
                  64'(keep_mask), 64'(exp_mask));
        check(int'(kept_count) == exp_kept, "R4", {tag, " kept_count"},
              64'(kept_count), 64'(exp_kept));
        check(underfill == (exp_kept < L), "R5", {tag, " underfill"},
              64'(underfill), 64'(exp_kept < L));
    endtask

    task automatic apply(input logic [NC*MW-1:0] m);
        @(negedge clk);
        in_valid   = 1'b1;
        in_metrics = m;
        @(negedge clk);
        in_valid   = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        logic [NC-1:0]    held_mask;
        logic [NC*CW-1:0] held_rank;
        logic [CW-1:0]    held_kept;
        logic             held_under;
        repeat (3) @(negedge clk);
        // R8: reset state
        check(out_valid == 0 && keep_mask == '0 && rank_flat == '0 && kept_count == '0
              && underfill == 0, "R8", "reset state", 64'(rank_flat), 64'd0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            apply(VECS[v]);
            check_result(VECS[v], $sformatf("vec%0d", v));
        end

        // R2/R5 directed: all equal metrics keep nobody
        apply(VECS[2]);
        check(keep_mask == '0 && kept_count == '0, "R2", "all tied dropped",
              64'(keep_mask), 64'd0);
        check(underfill == 1'b1, "R5", "all tied underfill", 64'(underfill), 64'd1);

        // R3 directed: ascending distinct metrics keep candidates 0..3
        apply(VECS[0]);
        check(keep_mask == 8'h0F, "R3", "smallest four kept", 64'(keep_mask), 64'h0F);

        // R7: idle cycle with changed metrics leaves outputs untouched
        held_mask = keep_mask; held_rank = rank_flat;
        held_kept = kept_count; held_under = underfill;
        in_metrics = VECS[1];
        @(negedge clk);
        check(out_valid == 1'b0, "R7", "out_valid low when idle", 64'(out_valid), 64'd0);
        check(keep_mask == held_mask && rank_flat == held_rank && kept_count == held_kept
              && underfill == held_under, "R7", "outputs held",
              64'(rank_flat), 64'(held_rank));

        // R6: back-to-back valid inputs, each result in its own cycle
        @(negedge clk);
        in_valid = 1'b1; in_metrics = VECS[3];
        @(negedge clk);
        in_metrics = VECS[6];
        check_result(VECS[3], "b2b first");
        @(negedge clk);
        in_valid = 1'b0;
        check_result(VECS[6], "b2b second");

        // R8: reset in the same cycle as in_valid wins
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; in_metrics = VECS[7];
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        check(out_valid == 0 && keep_mask == '0 && rank_flat == '0 && kept_count == '0
              && underfill == 0, "R8", "reset beats in_valid", 64'(rank_flat), 64'd0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule